// File: doc/BRIEF.md
# Size-Selectable Unsigned Multiply Unit

This execution unit forms the unsigned product of the implied accumulator and a general source value for an instruction-set datapath. A two-bit size code, together with a width-promotion control, chooses byte, word, doubleword or quadword operation. The unit reads only the low bits of both inputs that belong to that size. It returns the double-width product laid out the way the register file expects. In the byte case the whole 16-bit product lands in the accumulator result. In the wider cases the product splits into a high-result word and an accumulator-result word.

The multiply is done by an iterative radix-2 shift-add core rather than a single-cycle array. An operation of N bits occupies the unit for exactly N cycles after it is accepted, and then a one-cycle done pulse marks the results as valid. The unit also produces carry and overflow flags, which report whether the upper half of the product is nonzero. The four remaining arithmetic flags carry no defined meaning after this operation and are tied off.

Top module: `umul_unit`

## Requirements
- R1: Size decode: `size_sel` 2'b00 selects 8 bits and 2'b01 selects 16 bits, whatever the value of `widen`. When `size_sel[1]` is 1, the size is 32 bits with `widen`=0 and 64 bits with `widen`=1.
- R2: The factors are the low N bits of `acc_in` and of `src_in`, where N is the selected size. Input bits above N have no effect on any output.
- R3: Byte size: `acc_out[15:0]` holds the full 16-bit product, `acc_out[63:16]` is zero, `hi_out` is zero and `hi_we` is 0.
- R4: Word, doubleword and quadword sizes: `acc_out` holds the lower N bits of the 2N-bit product and `hi_out` holds the upper N bits. Bits of either output above N are zero, and `hi_we` is 1.
- R5: `cf` and `of` are both 1 when the upper half of the 2N-bit product is nonzero, and both 0 otherwise.
- R6: `sf`, `zf`, `af` and `pf` are undefined after the operation and are always driven to 0.
- R7: A `start` sampled while the unit is idle is accepted at that clock edge. `busy` is then high for exactly N cycles, and `done` is high for one cycle, starting N clock edges after the accepting edge. `busy` and `done` are never high together.
- R8: `start` is ignored while `busy` is high. The running operation completes with its original operands and size.
- R9: After reset, `busy`, `done`, `hi_we`, all flags, `acc_out` and `hi_out` are 0.
- R10: Once `done` has pulsed, `acc_out`, `hi_out`, `hi_we`, `cf` and `of` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiply (accepted only when idle) |
| size_sel | input | 2 | Operand size code |
| widen | input | 1 | Width promotion: turns the 32-bit code into 64-bit |
| acc_in | input | 64 | Implied accumulator operand |
| src_in | input | 64 | Source operand |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse when results become valid |
| acc_out | output | 64 | Accumulator result (whole byte product, or lower half) |
| hi_out | output | 64 | High-result value (upper half of the product) |
| hi_we | output | 1 | The high-result register is to be written |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag, don't care, tied to 0 |
| zf | output | 1 | Zero flag, don't care, tied to 0 |
| af | output | 1 | Auxiliary-carry flag, don't care, tied to 0 |
| pf | output | 1 | Parity flag, don't care, tied to 0 |

## Verification
The bench builds the unit with its default `XLEN` of 64. At that value all four sizes can be exercised, including the 64-by-64 case that needs the full 128-bit product register and the 64-iteration count. Because every size code and the promotion control remain reachable, the bench can drive garbage into the input bits above each size and check that they have no effect. It can also hit the boundary where the upper half of the product is exactly zero or exactly one at every width, and compare the measured latency against 8, 16, 32 and 64 cycles.

// File: rtl/umul_pkg.sv
// Package: shared types for the unsigned multiply unit.
// Assumes the datapath word is 64 bits, so the four sizes are 8/16/32/64.
package umul_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QUAD  = 2'd3
    } opsize_e;

    // Number of operand bits for a decoded size.
    function automatic int unsigned size_bits(opsize_e sz);
        case (sz)
            SZ_BYTE:  return 8;
            SZ_WORD:  return 16;
            SZ_DWORD: return 32;
            default:  return 64;
        endcase
    endfunction

endpackage

// File: rtl/umul_size_sel.sv
// Module: umul_size_sel
// Decodes the size code and promotion control into an effective size,
// and masks both factors down to that width. Purely combinational.
// Assumes XLEN = 64 so that all four sizes fit.
module umul_size_sel
    import umul_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CNT_W = $clog2(XLEN + 1)
) (
    input  logic [1:0]       size_sel,
    input  logic             widen,
    input  logic [XLEN-1:0]  acc_in,
    input  logic [XLEN-1:0]  src_in,
    output opsize_e          eff_size,
    output logic [CNT_W-1:0] iter_cnt,
    output logic [XLEN-1:0]  fac_a,
    output logic [XLEN-1:0]  fac_b
);

    logic [XLEN-1:0] mask;

    // Pick the effective size; promotion only matters for the wide code.
    always_comb begin
        case (size_sel)
            2'b00:   eff_size = SZ_BYTE;
            2'b01:   eff_size = SZ_WORD;
            default: eff_size = widen ? SZ_QUAD : SZ_DWORD;
        endcase
    end

    // Width mask and iteration count for the chosen size.
    always_comb begin
        iter_cnt = CNT_W'(size_bits(eff_size));
        case (eff_size)
            SZ_BYTE:  mask = XLEN'({8{1'b1}});
            SZ_WORD:  mask = XLEN'({16{1'b1}});
            SZ_DWORD: mask = XLEN'({32{1'b1}});
            default:  mask = '1;
        endcase
    end

    // Zero the factor bits above the selected width.
    always_comb begin
        fac_a = acc_in & mask;
        fac_b = src_in & mask;
    end

endmodule

// File: rtl/umul_shift_add.sv
// Module: umul_shift_add
// Radix-2 shift-add multiplier. One multiplier bit is retired per cycle.
// A load takes one edge, then 'iters' iteration edges follow, and the
// last one raises 'done' for a single cycle. Loads are refused while busy.
// Assumes the factors arrive already zero-extended above the active width.
module umul_shift_add #(
    parameter int XLEN   = 64,
    parameter int PROD_W = 2 * XLEN,
    parameter int CNT_W  = $clog2(XLEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [XLEN-1:0]   fac_a,
    input  logic [XLEN-1:0]   fac_b,
    input  logic [CNT_W-1:0]  iters,
    output logic              busy,
    output logic              done,
    output logic [PROD_W-1:0] prod
);

    logic [PROD_W-1:0] mcand_q;
    logic [XLEN-1:0]   mplier_q;
    logic [CNT_W-1:0]  cnt_q;

    // Load the operands, then add and shift once per cycle until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            cnt_q    <= '0;
            prod     <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else if (!busy && load) begin
            mcand_q  <= {{(PROD_W - XLEN){1'b0}}, fac_a};
            mplier_q <= fac_b;
            cnt_q    <= iters;
            prod     <= '0;
            busy     <= 1'b1;
            done     <= 1'b0;
        end else if (busy) begin
            if (mplier_q[0]) begin
                prod <= prod + mcand_q;
            end
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            cnt_q    <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R8: while busy, the count only steps down by one, whatever start does.
    assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q > CNT_W'(1)) |=> (busy && cnt_q == $past(cnt_q) - 1'b1));

    // R7: a done pulse always closes a busy interval.
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

endmodule

// File: rtl/umul_result_pack.sv
// Module: umul_result_pack
// Places the 128-bit product into the accumulator and high results for the
// latched size, derives carry/overflow, and ties off the undefined flags.
// Combinational. Assumes XLEN = 64.
module umul_result_pack
    import umul_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int PROD_W = 2 * XLEN
) (
    input  opsize_e           size_q,
    input  logic [PROD_W-1:0] prod,
    output logic [XLEN-1:0]   acc_out,
    output logic [XLEN-1:0]   hi_out,
    output logic              hi_we,
    output logic              cf,
    output logic              of,
    output logic              sf,
    output logic              zf,
    output logic              af,
    output logic              pf
);

    logic upper_nz;

    // Split the product per size; the byte case keeps everything in one word.
    always_comb begin
        case (size_q)
            SZ_BYTE: begin
                acc_out  = XLEN'(prod[15:0]);
                hi_out   = '0;
                hi_we    = 1'b0;
                upper_nz = |prod[15:8];
            end
            SZ_WORD: begin
                acc_out  = XLEN'(prod[15:0]);
                hi_out   = XLEN'(prod[31:16]);
                hi_we    = 1'b1;
                upper_nz = |prod[31:16];
            end
            SZ_DWORD: begin
                acc_out  = XLEN'(prod[31:0]);
                hi_out   = XLEN'(prod[63:32]);
                hi_we    = 1'b1;
                upper_nz = |prod[63:32];
            end
            default: begin
                acc_out  = prod[XLEN-1:0];
                hi_out   = prod[PROD_W-1:XLEN];
                hi_we    = 1'b1;
                upper_nz = |prod[PROD_W-1:XLEN];
            end
        endcase
    end

    // Carry and overflow both report a nonzero upper half.
    always_comb begin
        cf = upper_nz;
        of = upper_nz;
    end

    // Don't care: these flags are undefined after the multiply; fixed at 0.
    always_comb begin
        sf = 1'b0;
        zf = 1'b0;
        af = 1'b0;
        pf = 1'b0;
    end

endmodule

// File: rtl/umul_unit.sv
// Module: umul_unit (top)
// Size-selectable unsigned multiply with a start/done handshake.
// The size decoded at the accepting edge is latched, so the output layout
// is stable for the whole operation and after it.
// Assumes XLEN = 64; the size codes map to fixed 8/16/32/64-bit widths.
module umul_unit
    import umul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      size_sel,
    input  logic            widen,
    input  logic [XLEN-1:0] acc_in,
    input  logic [XLEN-1:0] src_in,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] acc_out,
    output logic [XLEN-1:0] hi_out,
    output logic            hi_we,
    output logic            cf,
    output logic            of,
    output logic            sf,
    output logic            zf,
    output logic            af,
    output logic            pf
);

    localparam int PROD_W = 2 * XLEN;
    localparam int CNT_W  = $clog2(XLEN + 1);

    opsize_e           eff_size;
    opsize_e           size_q;
    logic [CNT_W-1:0]  iter_cnt;
    logic [XLEN-1:0]   fac_a;
    logic [XLEN-1:0]   fac_b;
    logic [PROD_W-1:0] prod;

    umul_size_sel #(.XLEN(XLEN), .CNT_W(CNT_W)) u_sel (
        .size_sel (size_sel),
        .widen    (widen),
        .acc_in   (acc_in),
        .src_in   (src_in),
        .eff_size (eff_size),
        .iter_cnt (iter_cnt),
        .fac_a    (fac_a),
        .fac_b    (fac_b)
    );

    umul_shift_add #(.XLEN(XLEN), .PROD_W(PROD_W), .CNT_W(CNT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .fac_a (fac_a),
        .fac_b (fac_b),
        .iters (iter_cnt),
        .busy  (busy),
        .done  (done),
        .prod  (prod)
    );

    // Latch the decoded size when an operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZ_BYTE;
        end else if (start && !busy) begin
            size_q <= eff_size;
        end
    end

    umul_result_pack #(.XLEN(XLEN), .PROD_W(PROD_W)) u_pack (
        .size_q  (size_q),
        .prod    (prod),
        .acc_out (acc_out),
        .hi_out  (hi_out),
        .hi_we   (hi_we),
        .cf      (cf),
        .of      (of),
        .sf      (sf),
        .zf      (zf),
        .af      (af),
        .pf      (pf)
    );

    // R7: busy rises only at an accepted start.
    assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7: busy and done never overlap.
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3: without a high write, only the low 16 accumulator bits may be set.
    assert_byte_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hi_we) |-> (hi_out == '0 && acc_out[XLEN-1:16] == '0));

    // R10: while idle and no start arrives, the results stay put.
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(acc_out) && $stable(hi_out) && $stable(cf)));

endmodule

// File: tb/umul_unit_tb_top.sv
// Bench for umul_unit: directed corner cases plus seeded random operations,
// each compared against a 128-bit product computed in the bench.
module umul_unit_tb_top;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic [1:0]  size_sel;
    logic        widen;
    logic [63:0] acc_in;
    logic [63:0] src_in;
    logic        busy;
    logic        done;
    logic [63:0] acc_out;
    logic [63:0] hi_out;
    logic        hi_we;
    logic        cf;
    logic        of;
    logic        sf;
    logic        zf;
    logic        af;
    logic        pf;

    int checks = 0;
    int errors = 0;

    umul_unit #(.XLEN(64)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .size_sel (size_sel),
        .widen    (widen),
        .acc_in   (acc_in),
        .src_in   (src_in),
        .busy     (busy),
        .done     (done),
        .acc_out  (acc_out),
        .hi_out   (hi_out),
        .hi_we    (hi_we),
        .cf       (cf),
        .of       (of),
        .sf       (sf),
        .zf       (zf),
        .af       (af),
        .pf       (pf)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Operand width chosen by a size code and the promotion control (R1).
    function automatic int width_of(input logic [1:0] sz, input logic wd);
        if (sz == 2'b00) return 8;
        if (sz == 2'b01) return 16;
        return wd ? 64 : 32;
    endfunction

    function automatic logic [63:0] mask_of(input int n);
        return (n == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
    endfunction

    // Run one operation; optionally fire a second start mid-flight (R8).
    task automatic run_op(input logic [1:0] sz, input logic wd,
                          input logic [63:0] a, input logic [63:0] b,
                          input bit mid_start);
        int n = width_of(sz, wd);
        logic [63:0]  m = mask_of(n);
        logic [127:0] p = {64'd0, a & m} * {64'd0, b & m};
        logic [63:0]  e_lo, e_hi;
        logic         e_we, e_nz;
        int k;
        if (n == 8) begin
            e_lo = {48'd0, p[15:0]}; e_hi = 64'd0; e_we = 1'b0; e_nz = |p[15:8];
        end else if (n == 16) begin
            e_lo = {48'd0, p[15:0]}; e_hi = {48'd0, p[31:16]}; e_we = 1'b1; e_nz = |p[31:16];
        end else if (n == 32) begin
            e_lo = {32'd0, p[31:0]}; e_hi = {32'd0, p[63:32]}; e_we = 1'b1; e_nz = |p[63:32];
        end else begin
            e_lo = p[63:0]; e_hi = p[127:64]; e_we = 1'b1; e_nz = |p[127:64];
        end

        @(negedge clk);
        start = 1'b1; size_sel = sz; widen = wd; acc_in = a; src_in = b;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        chk(busy == 1'b1, "R7", "busy after accept", 128'(busy), 128'd1);
        if (mid_start) begin
            start = 1'b1; size_sel = 2'b00; acc_in = ~a; src_in = ~b;
        end
        while (!done && k < 100) begin
            @(negedge clk);
            start = 1'b0;
            k++;
            if (!done && k <= n) chk(busy == 1'b1, "R7", "busy held", 128'(busy), 128'd1);
        end
        chk(k - 1 == n, "R7 R1", "latency", 128'(k - 1), 128'(n));
        chk(busy == 1'b0, "R7", "busy at done", 128'(busy), 128'd0);
        chk(acc_out == e_lo, (n == 8) ? "R3 R2" : "R4 R2", "acc_out", 128'(acc_out), 128'(e_lo));
        chk(hi_out == e_hi, (n == 8) ? "R3" : "R4", "hi_out", 128'(hi_out), 128'(e_hi));
        chk(hi_we == e_we, (n == 8) ? "R3" : "R4", "hi_we", 128'(hi_we), 128'(e_we));
        chk(cf == e_nz && of == e_nz, "R5", "cf/of", 128'({cf, of}), 128'({e_nz, e_nz}));
        chk({sf, zf, af, pf} == 4'd0, "R6", "undefined flags", 128'({sf, zf, af, pf}), 128'd0);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done one cycle", 128'(done), 128'd0);
        chk(acc_out == e_lo && hi_out == e_hi && cf == e_nz, "R10", "hold after done",
            128'({acc_out, hi_out}), 128'({e_lo, e_hi}));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; size_sel = 2'b00; widen = 1'b0;
        acc_in = '0; src_in = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state at the ports.
        chk(busy == 0 && done == 0 && hi_we == 0, "R9", "ctrl after reset",
            128'({busy, done, hi_we}), 128'd0);
        chk(acc_out == 0 && hi_out == 0, "R9", "results after reset",
            128'({acc_out, hi_out}), 128'd0);
        chk({cf, of, sf, zf, af, pf} == 6'd0, "R9", "flags after reset",
            128'({cf, of, sf, zf, af, pf}), 128'd0);

        // Directed corners per size: 0, 1, all-ones, upper half 0 vs 1.
        for (int s = 0; s < 4; s++) begin
            logic [1:0] sz = (s < 2) ? 2'(s) : 2'b10;
            logic wd = (s == 3);
            int n = width_of(sz, wd);
            logic [63:0] m = mask_of(n);
            logic [63:0] top = 64'd1 << (n - 1);
            // Garbage above the width must be ignored (R2).
            run_op(sz, wd, ~m, 64'h0, 1'b0);
            run_op(sz, wd, 64'd1, 64'd1, 1'b0);
            run_op(sz, wd, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
            run_op(sz, wd, m, 64'd1 | ~m, 1'b0);       // upper half exactly zero
            run_op(sz, wd, top, 64'd2, 1'b0);           // upper half exactly one
            run_op(sz, wd, top, 64'd2, 1'b1);           // R8: mid-flight start ignored
        end
        // R1: promotion has no effect on byte and word codes; code 3 acts like 2.
        run_op(2'b00, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210, 1'b0);
        run_op(2'b01, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210, 1'b0);
        run_op(2'b11, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210, 1'b0);
        run_op(2'b11, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210, 1'b0);

        // Seeded random operations.
        for (int i = 0; i < 200; i++) begin
            logic [1:0]  sz = 2'($urandom() % 4);
            logic        wd = 1'($urandom() % 2);
            logic [63:0] a = {$urandom(), $urandom()};
            logic [63:0] b = {$urandom(), $urandom()};
            run_op(sz, wd, a, b, ($urandom() % 8) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule